// File: doc/BRIEF.md
# Per-Element Byte Reversal Stage

This stage sits in the operand and result paths between the register file and the arithmetic units. It reorders the bytes of one 64-bit word. On the arithmetic path a single reverse bit, taken from the instruction's mode field when that field selects simple operation, decides whether the bytes inside every element are mirrored. The element width sets how large each mirrored group is. The same reverse bit applies when operands are read and again when results are written back. Mirroring twice returns the original word, so the register contents always look little-endian to software. With the bit clear, data goes through untouched, and the big-endian setting has no effect on register-to-register arithmetic.

The stage also serves the load path. There, the whole 64-bit word is mirrored when the big-endian mode flag and the byte-reverse-load flag differ. The element width plays no part on that path. Decoding the mode field beyond the reverse bit, and all memory access, belong to other blocks.

Words enter and leave over valid/ready handshakes. A word transfers on a clock edge where its valid and ready are both high. An upstream source must keep its word and controls steady while `in_valid` is high and `in_ready` is low. The stage holds an offered output steady until `out_ready` takes it. With the default registered output there is one cycle of latency, and a word can be accepted in every cycle in which the downstream side also takes one.

Top module: `elem_byte_swap`

## Requirements
- R1: When `in_load` = 1 and `in_be` XOR `in_brev_ld` = 1, output byte k equals input byte 7-k for all k (byte k is bits 8k+7:8k), whatever `in_ew` and `in_rev` are.
- R2: When `in_load` = 1 and `in_be` equals `in_brev_ld`, the output word equals the input word.
- R3: When `in_load` = 0 and `in_rev` = 0, the output word equals the input word for every value of `in_ew`, `in_be` and `in_brev_ld`.
- R4: With `in_load` = 0, `in_rev` = 1 and `in_ew` = 2'b01 (16-bit elements), the output bytes from byte 0 upward are input bytes 1,0,3,2,5,4,7,6.
- R5: With `in_load` = 0, `in_rev` = 1 and `in_ew` = 2'b00 (8-bit elements), the output word equals the input word.
- R6: With `in_load` = 0, `in_rev` = 1 and `in_ew` = 2'b10 (32-bit elements), the bytes are mirrored inside each 4-byte group: output bytes 0..7 are input bytes 3,2,1,0,7,6,5,4.
- R7: With `in_load` = 0, `in_rev` = 1 and `in_ew` = 2'b11 (64-bit elements), all 8 bytes are mirrored.
- R8: Passing a result of the arithmetic path through the stage again with the same `in_ew` and `in_rev` returns the original word.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R10: `out_valid` is 0 during and right after reset. `in_ready` is 1 whenever `out_valid` is 0. With a registered output, a word accepted on one edge is offered on `out_valid` right after that edge.
- R11: Words leave in the order they were accepted, each exactly once, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word and controls are valid |
| in_ready | output | 1 | Stage can take the input word |
| in_data | input | 64 | Input word |
| in_ew | input | 2 | Element width: 00=8, 01=16, 10=32, 11=64 bits |
| in_load | input | 1 | 1 = load path, 0 = arithmetic path |
| in_rev | input | 1 | Arithmetic-path element reverse bit |
| in_be | input | 1 | Big-endian mode flag (load path only) |
| in_brev_ld | input | 1 | Byte-reverse-load instruction flag (load path only) |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 64 | Reordered word |

## Verification
The hardest case to reach is a new word waiting at the input while the output register is full and the downstream side is stalled. The stage must then hold both the stored word and the pending one without losing, duplicating or reordering either. The bench creates this by driving `out_ready` from a pseudo-random sequence while it sends words back to back with random widths, paths and flags. Back-pressure therefore lands on the same edges where inputs are waiting. Involution is checked by sending a stage result back in with unchanged controls and expecting the original word.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    EW_8  = 2'b00,
    EW_16 = 2'b01,
    EW_32 = 2'b10,
    EW_64 = 2'b11
  } ew_e;

  localparam int NUM_EW = 4;

  typedef struct packed {
    logic swap_en;
    ew_e  gran;
  } swap_ctrl_t;

endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
(
  input  logic       load_path,
  input  logic       rev_bit,
  input  logic       be_flag,
  input  logic       brev_ld,
  input  logic [1:0] ew,
  output swap_ctrl_t ctrl
);

  always_comb begin
    if (load_path) begin
      ctrl.swap_en = be_flag ^ brev_ld;
      ctrl.gran    = EW_64;
    end else begin
      ctrl.swap_en = rev_bit;
      ctrl.gran    = ew_e'(ew);
    end
  end

endmodule

// File: rtl/ebs_swap_net.sv
module ebs_swap_net
  import ebs_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  swap_ctrl_t               ctrl,
  output logic [NBYTES*BYTE_W-1:0] dout
);

  localparam int W = NBYTES * BYTE_W;

  logic [W-1:0] cand [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_gran
    localparam int GRP = ((1 << k) > NBYTES) ? NBYTES : (1 << k);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam int BASE = (i / GRP) * GRP;
      localparam int SRC  = BASE + (GRP - 1 - (i % GRP));
      assign cand[k][i*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    if (ctrl.swap_en) dout = cand[ctrl.gran];
    else              dout = din;
  end

endmodule

// File: rtl/ebs_out_stage.sv
module ebs_out_stage #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  if (OUT_REG) begin : g_reg
    logic         vld_q;
    logic [W-1:0] data_q;

    assign up_ready = !vld_q || dn_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (up_ready) begin
        vld_q <= up_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (up_valid && up_ready) data_q <= up_data;
    end

    assign dn_valid = vld_q;
    assign dn_data  = data_q;
  end else begin : g_comb
    assign up_ready = dn_ready;
    assign dn_valid = up_valid;
    assign dn_data  = up_data;
  end

endmodule

// File: rtl/elem_byte_swap.sv
module elem_byte_swap
  import ebs_pkg::*;
#(
  parameter int NBYTES  = 8,
  parameter int BYTE_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NBYTES*BYTE_W-1:0] in_data,
  input  logic [1:0]               in_ew,
  input  logic                     in_load,
  input  logic                     in_rev,
  input  logic                     in_be,
  input  logic                     in_brev_ld,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBYTES*BYTE_W-1:0] out_data
);

  localparam int DATA_W = NBYTES * BYTE_W;

  swap_ctrl_t        ctrl;
  logic [DATA_W-1:0] swapped;

  ebs_ctrl u_ctrl (
    .load_path (in_load),
    .rev_bit   (in_rev),
    .be_flag   (in_be),
    .brev_ld   (in_brev_ld),
    .ew        (in_ew),
    .ctrl      (ctrl)
  );

  ebs_swap_net #(
    .NBYTES (NBYTES),
    .BYTE_W (BYTE_W)
  ) u_net (
    .din  (in_data),
    .ctrl (ctrl),
    .dout (swapped)
  );

  ebs_out_stage #(
    .W       (DATA_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (swapped),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic [1:0]   in_ew,
  input logic         in_load,
  input logic         in_rev,
  input logic         in_be,
  input logic         in_brev_ld,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R10: an empty output side never refuses input
  p_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9: stalled output holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  if (OUT_REG) begin : g_reg_chk
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_load && !in_rev) |=> (out_data == $past(in_data)));

    p_load_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_load && (in_be == in_brev_ld)) |=> (out_data == $past(in_data)));

    p_bytes8_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_load && in_ew == 2'b00) |=> (out_data == $past(in_data)));

    p_load_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_load && (in_be != in_brev_ld)) |=>
      (out_data[7:0] == $past(in_data[W-1:W-8]) &&
       out_data[W-1:W-8] == $past(in_data[7:0])));
  end else begin : g_comb_chk
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_load && !in_rev) |-> (out_data == in_data));

    p_load_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_load && (in_be == in_brev_ld)) |-> (out_data == in_data));

    p_bytes8_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_load && in_ew == 2'b00) |-> (out_data == in_data));

    p_load_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_load && (in_be != in_brev_ld)) |->
      (out_data[7:0] == in_data[W-1:W-8] &&
       out_data[W-1:W-8] == in_data[7:0]));
  end

endmodule

bind elem_byte_swap ebs_checker #(
  .W       (DATA_W),
  .OUT_REG (OUT_REG)
) u_ebs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_ew      (in_ew),
  .in_load    (in_load),
  .in_rev     (in_rev),
  .in_be      (in_be),
  .in_brev_ld (in_brev_ld),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data)
);

// File: tb/elem_byte_swap_bench.sv
`timescale 1ns/1ps
module elem_byte_swap_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_ew = 2'b00;
  logic        in_load = 1'b0;
  logic        in_rev = 1'b0;
  logic        in_be = 1'b0;
  logic        in_brev_ld = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] cur_exp = '0;
  string       cur_tag = "";
  logic [63:0] q_exp[$];
  string       q_tag[$];

  bit          stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  elem_byte_swap u_elem_byte_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_ew      (in_ew),
    .in_load    (in_load),
    .in_rev     (in_rev),
    .in_be      (in_be),
    .in_brev_ld (in_brev_ld),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  function automatic logic [63:0] model(input logic [63:0] d, input logic [1:0] ew,
                                        input logic ld, input logic rv,
                                        input logic be, input logic bl);
    int grp;
    logic [63:0] r;
    if (ld) grp = (be ^ bl) ? 8 : 1;
    else    grp = rv ? (1 << ew) : 1;
    for (int i = 0; i < 8; i++) begin
      int src;
      src = (i / grp) * grp + (grp - 1 - (i % grp));
      r[i*8 +: 8] = d[src*8 +: 8];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] ew, input logic ld,
                                   input logic rv, input logic be, input logic bl);
    if (ld) return (be ^ bl) ? "R1" : "R2";
    if (!rv) return "R3";
    case (ew)
      2'b00:   return "R5";
      2'b01:   return "R4";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic fail(input string req, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  // downstream ready pattern, changes 2 ns after the falling edge
  always begin
    @(negedge clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor, 2 ns before each rising edge
  bit          stall_prev = 0;
  bit          acc_prev = 0;
  logic [63:0] stall_data = '0;
  always begin
    @(negedge clk);
    #8;
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0) fail("R10", {63'd0, out_valid}, 64'd0);
      stall_prev = 0;
      acc_prev = 0;
    end else begin
      if (stall_prev) begin
        checks++;
        if (!(out_valid === 1'b1 && out_data === stall_data)) fail("R9", out_data, stall_data);
      end
      if (acc_prev) begin
        checks++;
        if (out_valid !== 1'b1) fail("R10", {63'd0, out_valid}, 64'd1);
      end
      if (out_valid !== 1'b1) begin
        checks++;
        if (in_ready !== 1'b1) fail("R10", {63'd0, in_ready}, 64'd1);
      end
      if (in_valid && in_ready) begin
        q_exp.push_back(cur_exp);
        q_tag.push_back(cur_tag);
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q_exp.size() == 0) begin
          fail("R11", out_data, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          if (out_data !== e) fail(t, out_data, e);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      acc_prev   = in_valid && in_ready;
    end
  end

  // call aligned 2 ns after a falling edge; returns aligned the same way
  task automatic send(input logic [63:0] d, input logic [1:0] ew, input logic ld,
                      input logic rv, input logic be, input logic bl,
                      input logic [63:0] exp, input string tag);
    in_valid   = 1'b1;
    in_data    = d;
    in_ew      = ew;
    in_load    = ld;
    in_rev     = rv;
    in_be      = be;
    in_brev_ld = bl;
    cur_exp    = exp;
    cur_tag    = tag;
    forever begin
      bit fire;
      #6;
      fire = in_ready;
      @(negedge clk);
      #2;
      if (fire) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_m(input logic [63:0] d, input logic [1:0] ew, input logic ld,
                        input logic rv, input logic be, input logic bl);
    send(d, ew, ld, rv, be, bl, model(d, ew, ld, rv, be, bl), tag_of(ew, ld, rv, be, bl));
  endtask

  initial begin
    logic [63:0] seq = 64'h0706050403020100;
    logic [63:0] x   = 64'h1122334455667788;
    logic [63:0] y;
    repeat (4) @(negedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    #2;

    // directed
    send(seq, 2'b01, 0, 1, 0, 0, 64'h0607040502030001, "R4");
    send(seq, 2'b00, 0, 1, 1, 0, seq, "R5");
    send(seq, 2'b10, 0, 1, 0, 1, 64'h0405060700010203, "R6");
    send(seq, 2'b11, 0, 1, 0, 0, 64'h0001020304050607, "R7");
    send(seq, 2'b01, 1, 0, 1, 0, 64'h0001020304050607, "R1");
    send(seq, 2'b00, 1, 1, 0, 1, 64'h0001020304050607, "R1");
    send(seq, 2'b10, 1, 1, 1, 1, seq, "R2");
    send(seq, 2'b01, 1, 0, 0, 0, seq, "R2");
    send(seq, 2'b11, 0, 0, 1, 0, seq, "R3");
    send(seq, 2'b01, 0, 0, 0, 1, seq, "R3");

    // involution, R8
    for (int w = 0; w < 4; w++) begin
      y = model(x, w[1:0], 0, 1, 0, 0);
      send(x, w[1:0], 0, 1, 0, 0, y, "R8");
      send(y, w[1:0], 0, 1, 1, 1, x, "R8");
    end

    // random traffic under back-pressure, R11 ordering
    stall_mode = 1;
    for (int n = 0; n < 300; n++) begin
      logic [63:0] d;
      logic [5:0]  c;
      d = {$urandom, $urandom};
      c = 6'($urandom);
      send_m(d, c[1:0], c[2], c[3], c[4], c[5]);
      if (c[5] && c[4] && c[0]) begin
        @(negedge clk);
        #2;
      end
    end
    stall_mode = 0;
    repeat (10) @(negedge clk);
    #2;
    checks++;
    if (q_exp.size() != 0) fail("R11", 64'(q_exp.size()), 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule